// File: doc/BRIEF.md
# Transceiver Link Reset Sequencer

This block brings a multi-lane serial transceiver link out of reset in a fixed order. Software drives one enable bit. While that bit is low, everything is held in reset: the transceiver reset controller, the link PLL reset logic, the PHY and the link layer. Software first programs rate and clock-select settings elsewhere and then sets the enable. The block holds reset for a minimum time and then releases the PLLs. It lets the PHY out of reset only once every PLL reports lock. It releases the link layer last, once every lane reports PHY-ready.

The block also monitors the link. Each PLL-lock input and each lane-ready input passes through a two-flop synchronizer and is then reduced to an "all locked" flag and an "all ready" flag. A single registered link-up status bit, which software polls, is the AND of the final sequencing state and both flags. That status bit falls as soon as any monitored input drops.

If a PLL does not lock within a timeout, the block pulses the PLL reset again. Clearing the enable aborts the sequence within one clock. The one exception is a transceiver reconfiguration access that is still in flight: in that case the abort waits until the access ends.

Top module: `xcvr_link_rst_seq`

## Requirements
- R1: While `rst` is high, and afterwards until `run_en` is set, `glob_rst_o`, `pll_rst_o`, `phy_rst_o` and `link_rst_o` are all 1 and `link_up_o` is 0.
- R2: The first rising edge that samples `run_en`=1 counts as edge 1. `pll_rst_o` and `glob_rst_o` both fall on edge RST_HOLD_CYC.
- R3: `phy_rst_o` stays 1 until every `pll_locked_i` bit is 1. It falls on the 4th rising edge after the last lock bit rises (two synchronizer flops, one reduce flop, one output flop). `phy_rst_o` is never 0 while `pll_rst_o` is 1.
- R4: `link_rst_o` falls, and `link_up_o` rises, on the 4th rising edge after the last `lane_ready_i` bit rises, provided the PHY is already released. `link_rst_o` is never 0 while `phy_rst_o` is 1.
- R5: In the link-up state, a drop of any `pll_locked_i` or `lane_ready_i` bit clears `link_up_o` on the 4th rising edge after the drop. The reset outputs stay as they are.
- R6: When a rising edge samples `run_en`=0 and `cfg_busy_i`=0, all four reset outputs are 1 and `link_up_o` is 0 after that same edge.
- R7: While `run_en`=0 and `cfg_busy_i`=1, the reset outputs keep their values. The abort of R6 happens on the first edge that samples `cfg_busy_i`=0.
- R8: If lock is lost after PHY release but before link-up, `phy_rst_o` returns to 1 on the 4th edge after the drop and `pll_rst_o` stays 0.
- R9: If lock is not seen within LOCK_TIMEOUT_CYC edges after PLL release, `pll_rst_o` returns to 1 on edge LOCK_TIMEOUT_CYC. The RST_HOLD_CYC hold of R2 then repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Software enable; 1 starts bring-up, 0 requests full reset |
| cfg_busy_i | input | 1 | A transceiver reconfiguration access is in flight |
| pll_locked_i | input | NUM_PLLS | Per-PLL lock flags, asynchronous |
| lane_ready_i | input | NUM_LANES | Per-lane PHY-ready flags, asynchronous |
| glob_rst_o | output | 1 | Global reset covering reset controller, PLL, PHY and link layer |
| pll_rst_o | output | 1 | Link PLL reset |
| phy_rst_o | output | 1 | PHY reset |
| link_rst_o | output | 1 | Link-layer reset |
| link_up_o | output | 1 | Aggregate status: link is up |

## Verification
The hardest situations to reach are the ones where the inputs change while the sequencer waits in a middle state. Examples are lock lost after the PHY is released but before every lane is ready, and an enable cleared while a reconfiguration access is in flight. The stimulus drives the sequencer into the intermediate state by raising the locks and holding the ready inputs low, then drops a single lock bit. For the deferred abort, the stimulus raises the busy input before clearing the enable. Each input change is followed by counted edges, so the synchronizer latency is checked one cycle before and one cycle at the expected change.

// File: rtl/xlrs_pkg.sv
package xlrs_pkg;

  typedef enum logic [1:0] {
    ST_HOLD       = 2'd0,
    ST_LOCK_WAIT  = 2'd1,
    ST_READY_WAIT = 2'd2,
    ST_UP         = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic glob;
    logic pll;
    logic phy;
    logic link;
  } rst_vec_t;

  localparam rst_vec_t RST_ALL = '{glob: 1'b1, pll: 1'b1, phy: 1'b1, link: 1'b1};

  // Reset pattern held in each sequencing state.
  function automatic rst_vec_t rst_for(seq_state_e s);
    rst_vec_t v;
    case (s)
      ST_HOLD:       v = RST_ALL;
      ST_LOCK_WAIT:  v = '{glob: 1'b0, pll: 1'b0, phy: 1'b1, link: 1'b1};
      ST_READY_WAIT: v = '{glob: 1'b0, pll: 1'b0, phy: 1'b0, link: 1'b1};
      default:       v = '{glob: 1'b0, pll: 1'b0, phy: 1'b0, link: 1'b0};
    endcase
    return v;
  endfunction

endpackage

// File: rtl/xlrs_sync_bank.sv
module xlrs_sync_bank #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[LAST];
  end

endmodule

// File: rtl/xlrs_lane_monitor.sv
module xlrs_lane_monitor #(
  parameter int NUM_PLLS    = 2,
  parameter int NUM_LANES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PLLS-1:0]  pll_locked_i,
  input  logic [NUM_LANES-1:0] lane_ready_i,
  output logic                 lock_ok,
  output logic                 ready_ok
);

  logic [NUM_PLLS-1:0]  lock_s;
  logic [NUM_LANES-1:0] ready_s;

  xlrs_sync_bank #(.WIDTH(NUM_PLLS), .STAGES(SYNC_STAGES)) u_lock_sync (
    .clk (clk),
    .rst (rst),
    .d   (pll_locked_i),
    .q   (lock_s)
  );

  xlrs_sync_bank #(.WIDTH(NUM_LANES), .STAGES(SYNC_STAGES)) u_ready_sync (
    .clk (clk),
    .rst (rst),
    .d   (lane_ready_i),
    .q   (ready_s)
  );

  // Registered wide AND keeps the reduce tree out of the FSM path.
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_ok  <= 1'b0;
      ready_ok <= 1'b0;
    end else begin
      lock_ok  <= &lock_s;
      ready_ok <= &ready_s;
    end
  end

endmodule

// File: rtl/xlrs_seq_fsm.sv
module xlrs_seq_fsm
  import xlrs_pkg::*;
#(
  parameter int RST_HOLD_CYC    = 8,
  parameter int LOCK_TIMEOUT_CYC = 40
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     run_en,
  input  logic     cfg_busy,
  input  logic     lock_ok,
  input  logic     ready_ok,
  output rst_vec_t rst_q,
  output logic     link_up_q
);

  localparam int CNT_MAX = (RST_HOLD_CYC > LOCK_TIMEOUT_CYC) ? RST_HOLD_CYC : LOCK_TIMEOUT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(LOCK_TIMEOUT_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!run_en) begin
      // Abort is deferred while a reconfiguration access runs.
      if (!cfg_busy) begin
        state_d = ST_HOLD;
        cnt_d   = '0;
      end
    end else begin
      case (state_q)
        ST_HOLD: begin
          if (cnt_q == HOLD_LAST) begin
            state_d = ST_LOCK_WAIT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_LOCK_WAIT: begin
          if (lock_ok) begin
            state_d = ST_READY_WAIT;
            cnt_d   = '0;
          end else if (cnt_q == TMO_LAST) begin
            state_d = ST_HOLD;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_READY_WAIT: begin
          if (!lock_ok) begin
            state_d = ST_LOCK_WAIT;
            cnt_d   = '0;
          end else if (ready_ok) begin
            state_d = ST_UP;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_HOLD;
      cnt_q     <= '0;
      rst_q     <= RST_ALL;
      link_up_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      rst_q     <= rst_for(state_d);
      link_up_q <= (state_d == ST_UP) && lock_ok && ready_ok;
    end
  end

endmodule

// File: rtl/xcvr_link_rst_seq.sv
module xcvr_link_rst_seq
  import xlrs_pkg::*;
#(
  parameter int NUM_PLLS         = 2,
  parameter int NUM_LANES        = 4,
  parameter int SYNC_STAGES      = 2,
  parameter int RST_HOLD_CYC     = 8,
  parameter int LOCK_TIMEOUT_CYC = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run_en,
  input  logic                 cfg_busy_i,
  input  logic [NUM_PLLS-1:0]  pll_locked_i,
  input  logic [NUM_LANES-1:0] lane_ready_i,
  output logic                 glob_rst_o,
  output logic                 pll_rst_o,
  output logic                 phy_rst_o,
  output logic                 link_rst_o,
  output logic                 link_up_o
);

  logic     lock_ok;
  logic     ready_ok;
  rst_vec_t rst_v;

  xlrs_lane_monitor #(
    .NUM_PLLS    (NUM_PLLS),
    .NUM_LANES   (NUM_LANES),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_mon (
    .clk          (clk),
    .rst          (rst),
    .pll_locked_i (pll_locked_i),
    .lane_ready_i (lane_ready_i),
    .lock_ok      (lock_ok),
    .ready_ok     (ready_ok)
  );

  xlrs_seq_fsm #(
    .RST_HOLD_CYC     (RST_HOLD_CYC),
    .LOCK_TIMEOUT_CYC (LOCK_TIMEOUT_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .cfg_busy  (cfg_busy_i),
    .lock_ok   (lock_ok),
    .ready_ok  (ready_ok),
    .rst_q     (rst_v),
    .link_up_q (link_up_o)
  );

  assign glob_rst_o = rst_v.glob;
  assign pll_rst_o  = rst_v.pll;
  assign phy_rst_o  = rst_v.phy;
  assign link_rst_o = rst_v.link;

endmodule

// File: rtl/xcvr_link_rst_seq_chk.sv
module xcvr_link_rst_seq_chk (
  input logic clk,
  input logic rst,
  input logic run_en,
  input logic cfg_busy_i,
  input logic lock_ok,
  input logic ready_ok,
  input logic glob_rst_o,
  input logic pll_rst_o,
  input logic phy_rst_o,
  input logic link_rst_o,
  input logic link_up_o
);

  p_glob_covers_all_r1: assert property (@(posedge clk) disable iff (rst)
    glob_rst_o |-> (pll_rst_o && phy_rst_o && link_rst_o && !link_up_o));

  p_phy_after_pll_r3: assert property (@(posedge clk) disable iff (rst)
    !phy_rst_o |-> !pll_rst_o);

  p_phy_needs_lock_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(phy_rst_o) |-> $past(lock_ok));

  p_link_after_phy_r4: assert property (@(posedge clk) disable iff (rst)
    !link_rst_o |-> !phy_rst_o);

  p_up_gated_r5: assert property (@(posedge clk) disable iff (rst)
    link_up_o |-> ($past(lock_ok) && $past(ready_ok) && !link_rst_o));

  p_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !cfg_busy_i) |=> (glob_rst_o && pll_rst_o && phy_rst_o && link_rst_o && !link_up_o));

  p_busy_defers_r7: assert property (@(posedge clk) disable iff (rst)
    (!run_en && cfg_busy_i) |=> $stable({pll_rst_o, phy_rst_o, link_rst_o}));

endmodule

bind xcvr_link_rst_seq xcvr_link_rst_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .run_en     (run_en),
  .cfg_busy_i (cfg_busy_i),
  .lock_ok    (lock_ok),
  .ready_ok   (ready_ok),
  .glob_rst_o (glob_rst_o),
  .pll_rst_o  (pll_rst_o),
  .phy_rst_o  (phy_rst_o),
  .link_rst_o (link_rst_o),
  .link_up_o  (link_up_o)
);

// File: tb/xcvr_link_rst_seq_tb.sv
module xcvr_link_rst_seq_tb_top;

  localparam int NP   = 2;
  localparam int NL   = 4;
  localparam int HOLD = 8;
  localparam int TMO  = 40;
  localparam int LAT  = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_en = 1'b0;
  logic          cfg_busy = 1'b0;
  logic [NP-1:0] locks = '0;
  logic [NL-1:0] ready = '0;
  logic          glob_rst, pll_rst, phy_rst, link_rst, link_up;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  xcvr_link_rst_seq #(
    .NUM_PLLS(NP), .NUM_LANES(NL), .SYNC_STAGES(2),
    .RST_HOLD_CYC(HOLD), .LOCK_TIMEOUT_CYC(TMO)
  ) dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .cfg_busy_i(cfg_busy),
    .pll_locked_i(locks), .lane_ready_i(ready),
    .glob_rst_o(glob_rst), .pll_rst_o(pll_rst), .phy_rst_o(phy_rst),
    .link_rst_o(link_rst), .link_up_o(link_up)
  );

  // Wait n rising edges, then move 1 ns past the edge.
  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {glob_rst, pll_rst, phy_rst, link_rst, link_up};
  endfunction

  task automatic do_reset();
    rst = 1'b1; run_en = 1'b0; cfg_busy = 1'b0; locks = '0; ready = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic bring_up();
    run_en = 1'b1;
    tick(HOLD);
    locks = '1;
    tick(LAT);
    ready = '1;
    tick(LAT);
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    tick(2);
    chk("R1", "outputs in reset", outs(), 5'b11110);
    rst = 1'b0;
    tick(20);
    chk("R1", "outputs idle without enable", outs(), 5'b11110);
  endtask

  task automatic t_hold_release();
    do_reset();
    run_en = 1'b1;
    tick(HOLD - 1);
    chk("R2", "before hold ends", outs(), 5'b11110);
    tick(1);
    chk("R2", "pll and global released", outs(), 5'b00110);
  endtask

  task automatic t_phy_release();
    do_reset();
    run_en = 1'b1;
    tick(HOLD);
    locks = 2'b01;
    tick(10);
    chk("R3", "partial lock keeps phy reset", outs(), 5'b00110);
    locks = 2'b11;
    tick(LAT - 1);
    chk("R3", "phy still reset one edge early", outs(), 5'b00110);
    tick(1);
    chk("R3", "phy released", outs(), 5'b00010);
  endtask

  task automatic t_link_release();
    do_reset();
    run_en = 1'b1;
    tick(HOLD);
    locks = '1;
    tick(LAT);
    ready = 4'b0111;
    tick(10);
    chk("R4", "missing lane keeps link reset", outs(), 5'b00010);
    ready = 4'b1111;
    tick(LAT - 1);
    chk("R4", "link reset one edge early", outs(), 5'b00010);
    tick(1);
    chk("R4", "link released and up", outs(), 5'b00001);
  endtask

  task automatic t_status_drop();
    do_reset();
    bring_up();
    chk("R5", "up before drop", outs(), 5'b00001);
    ready[3] = 1'b0;
    tick(LAT - 1);
    chk("R5", "status one edge before ready drop lands", outs(), 5'b00001);
    tick(1);
    chk("R5", "status cleared by lane drop", outs(), 5'b00000);
    ready[3] = 1'b1;
    tick(LAT);
    chk("R5", "status back", outs(), 5'b00001);
    locks[1] = 1'b0;
    tick(LAT);
    chk("R5", "status cleared by lock drop", outs(), 5'b00000);
  endtask

  task automatic t_abort();
    do_reset();
    bring_up();
    run_en = 1'b0;
    tick(1);
    chk("R6", "abort within one edge", outs(), 5'b11110);
  endtask

  task automatic t_busy_defer();
    do_reset();
    bring_up();
    cfg_busy = 1'b1;
    run_en = 1'b0;
    tick(5);
    chk("R7", "resets held during access", outs(), 5'b00001);
    cfg_busy = 1'b0;
    tick(1);
    chk("R7", "abort after access ends", outs(), 5'b11110);
  endtask

  task automatic t_lock_loss_mid();
    do_reset();
    run_en = 1'b1;
    tick(HOLD);
    locks = '1;
    tick(LAT);
    chk("R8", "waiting for ready", outs(), 5'b00010);
    locks[0] = 1'b0;
    tick(LAT - 1);
    chk("R8", "phy still released", outs(), 5'b00010);
    tick(1);
    chk("R8", "phy reset again", outs(), 5'b00110);
  endtask

  task automatic t_lock_timeout();
    do_reset();
    run_en = 1'b1;
    tick(HOLD);
    chk("R9", "pll released", outs(), 5'b00110);
    tick(TMO - 1);
    chk("R9", "before timeout", outs(), 5'b00110);
    tick(1);
    chk("R9", "pll reset pulsed again", outs(), 5'b11110);
    tick(HOLD);
    chk("R9", "second release", outs(), 5'b00110);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected<=100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    t_reset_state();
    t_hold_release();
    t_phy_release();
    t_link_release();
    t_status_drop();
    t_abort();
    t_busy_defer();
    t_lock_loss_mid();
    t_lock_timeout();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule